// File: doc/BRIEF.md
# Memory and I/O Bus Cycle Controller

This block is a bus master sequencer. It takes one request at a time from a processor-side handshake and plays it out as timed cycles on a shared address and data bus. The request carries a byte address, write data, a direction bit, a space bit and a burst bit. The space bit chooses between memory space and a separate I/O space, and each space has its own read strobe and its own write strobe. Memory-mapped peripherals therefore see the memory strobes.

Every bus operation has three phases: an address clock, a wait clock and an end clock. The address and the strobe appear together in the address clock. Write data is driven from the wait clock onward. The device's ready line is sampled only in the wait clock, and each sample that is low repeats that clock as a wait state. A burst read runs four memory reads back to back, each address one word (in bytes) above the last. Each captured word is returned with a one-clock valid pulse. A one-clock acknowledge closes the transaction, and at least one clock with every strobe low separates transactions.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is held, all four strobes, `req_ack`, `rd_valid` and `bus_dout_en` are low, and `bus_addr` and `bus_dout` are zero.
- R2: A request is accepted only on a clock edge where the controller is idle and `req_valid` is high. Address, write data, direction, space and burst are captured at that edge, and later changes to the request inputs do not affect the running transaction. The first strobe appears in the clock after acceptance. With `req_valid` low, the bus stays quiet.
- R3: With `bus_ready` high in the wait clock, a single read holds its read strobe and address for exactly three clocks. `bus_din` is captured at the end of the third clock and presented on `rd_data`, with `rd_valid` high for one clock, in the following clock.
- R4: A write raises its write strobe together with the address in the first clock. `bus_dout_en` is low in the first clock, and `bus_dout` carries the write data only in the second and third clocks. At zero wait, the strobe lasts three clocks.
- R5: `bus_ready` is sampled only in the wait clock. Each wait clock that sees `bus_ready` low is repeated as a wait state, with the strobe, the address and the write data held. Ready in the address clock or the end clock has no effect.
- R6: A memory read with `req_burst` = 1 performs 4 beats at addresses base + k*(DATA_W/8) modulo 2^ADDR_W, for k = 0..3. The read strobe stays high through all beats. `rd_valid` pulses once per word, in the clock after that beat's end clock.
- R7: `req_burst` is ignored for writes and for I/O-space accesses, which run a single beat.
- R8: `req_io` = 1 uses `io_rd`/`io_wr` and `req_io` = 0 uses `mem_rd`/`mem_wr`. No two strobes are ever high together. Strobe vector order in checks: {mem_rd, mem_wr, io_rd, io_wr}.
- R9: `req_ack` is high for exactly one clock: the clock after the last beat's end clock. All strobes are low in that clock and in the clock after it. `req_ack` is low in every other clock.
- R10: While no strobe is high, `bus_addr` is zero. Outside a write's data clocks, `bus_dout_en` is low and `bus_dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request; held until acknowledged |
| req_addr | input | ADDR_W | Byte address of the first beat |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_burst | input | 1 | 1 = four-beat memory read |
| req_ack | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-clock pulse per captured word |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data from the bus |
| bus_ready | input | 1 | Device ready, sampled in the wait clock |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
The bench builds the controller with ADDR_W=8, DATA_W=16 and BEATS=4. The two-byte word makes the burst step visibly the word size in bytes rather than one. The narrow address lets a burst that starts at 0xFC run through 0xFE into 0x00 and 0x02, so the address wrap is exercised. Wait counts of zero to three across both spaces and both directions, together with request inputs that are scrambled after acceptance, put the wait-state, space-select and capture rules within reach of a per-clock comparison.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_WAIT,
      PH_END,
      PH_DONE
   } phase_t;

   // strobe index = {space, direction}
   localparam int STB_N      = 4;
   localparam int STB_MEM_RD = 0;
   localparam int STB_MEM_WR = 1;
   localparam int STB_IO_RD  = 2;
   localparam int STB_IO_WR  = 3;
endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
   import bcc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   ready,
   input  logic   last_beat,
   output phase_t phase
);
   phase_t nxt;

   always_comb begin
      nxt = phase;
      unique case (phase)
         PH_IDLE: if (start) nxt = PH_ADDR;
         PH_ADDR: nxt = PH_WAIT;
         PH_WAIT: if (ready) nxt = PH_END;
         PH_END:  nxt = last_beat ? PH_DONE : PH_ADDR;
         PH_DONE: nxt = PH_IDLE;
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= nxt;
   end

   // R5
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && !ready) |=> (phase == PH_WAIT));

   // R3
   addr_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ADDR) |=> (phase == PH_WAIT));

   // R2
   idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));
endmodule

// File: rtl/bcc_addr_gen.sv
module bcc_addr_gen #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BEATS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic [AW-1:0] base_in,
   input  logic          burst_in,
   output logic [AW-1:0] addr,
   output logic          last
);
   localparam int BYTES = DW / 8;
   localparam int BW    = $clog2(BEATS);
   localparam bit POW2  = ((BYTES & (BYTES - 1)) == 0);
   localparam int SH    = $clog2(BYTES);

   logic [AW-1:0] base_q;
   logic [BW-1:0] beat_q;
   logic          burst_q;
   logic [AW-1:0] offs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         beat_q  <= '0;
         burst_q <= 1'b0;
      end else if (load) begin
         base_q  <= base_in;
         beat_q  <= '0;
         burst_q <= burst_in;
      end else if (adv) begin
         beat_q  <= beat_q + 1'b1;
      end
   end

   generate
      if (POW2) begin : g_shift
         assign offs = AW'(beat_q) << SH;
      end else begin : g_mul
         assign offs = AW'(beat_q) * AW'(BYTES);
      end
   endgenerate

   assign addr = base_q + offs;
   assign last = !burst_q || (beat_q == BW'(BEATS - 1));

   // R6
   single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_q |-> (beat_q == '0));

   // R2
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(base_q));
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
   import bcc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int BEATS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_write,
   input  logic              req_io,
   input  logic              req_burst,
   output logic              req_ack,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_dout_en,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              bus_ready,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr
);
   initial begin
      width_ok: assert (DATA_W >= 8 && DATA_W % 8 == 0)
         else $fatal(1, "DATA_W must be a whole number of bytes");
      beats_ok: assert (BEATS >= 2)
         else $fatal(1, "BEATS must be at least 2");
      addr_ok: assert (ADDR_W > $clog2(BEATS))
         else $fatal(1, "ADDR_W too narrow for BEATS");
   end

   phase_t            phase;
   logic              start, active, data_ph, last, adv, end_rd;
   logic              wr_q, io_q;
   logic [DATA_W-1:0] wdata_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [STB_N-1:0]  stb;
   logic [1:0]        sel;

   assign start  = (phase == PH_IDLE) && req_valid;
   assign active = (phase == PH_ADDR) || (phase == PH_WAIT) || (phase == PH_END);
   assign adv    = (phase == PH_END) && !last;
   assign end_rd = (phase == PH_END) && !wr_q;

   bcc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ready     (bus_ready),
      .last_beat (last),
      .phase     (phase)
   );

   bcc_addr_gen #(.AW(ADDR_W), .DW(DATA_W), .BEATS(BEATS)) u_agen (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .adv      (adv),
      .base_in  (req_addr),
      .burst_in (req_burst && !req_write && !req_io),
      .addr     (cur_addr),
      .last     (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         io_q    <= 1'b0;
         wdata_q <= '0;
      end else if (start) begin
         wr_q    <= req_write;
         io_q    <= req_io;
         wdata_q <= req_wdata;
      end
   end

   assign sel = {io_q, wr_q};

   generate
      for (genvar i = 0; i < STB_N; i++) begin : g_stb
         assign stb[i] = active && (sel == 2'(i));
      end
   endgenerate

   assign mem_rd = stb[STB_MEM_RD];
   assign mem_wr = stb[STB_MEM_WR];
   assign io_rd  = stb[STB_IO_RD];
   assign io_wr  = stb[STB_IO_WR];

   assign bus_addr    = active ? cur_addr : '0;
   assign data_ph     = wr_q && ((phase == PH_WAIT) || (phase == PH_END));
   assign bus_dout_en = data_ph;
   assign bus_dout    = data_ph ? wdata_q : '0;
   assign req_ack     = (phase == PH_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= end_rd;
         if (end_rd) rd_data <= bus_din;
      end
   end

   // R8
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

   // R9
   ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> !(mem_rd || mem_wr || io_rd || io_wr || bus_dout_en));

   // R9
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   // R4
   wdata_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr || io_wr) |-> !bus_dout_en);

   // R4
   dout_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dout_en |-> (mem_wr || io_wr));

   // R3
   capture_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(mem_rd || io_rd));

   // R10
   addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd || mem_wr || io_rd || io_wr) |-> (bus_addr == '0));
endmodule

// File: tb/bus_cycle_ctrl_test.sv
module bus_cycle_ctrl_test;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NB = 4;
   localparam int BY = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_write = 1'b0, req_io = 1'b0, req_burst = 1'b0;
   logic          req_ack, rd_valid, bus_dout_en;
   logic [DW-1:0] rd_data, bus_dout;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_din = '0;
   logic          bus_ready = 1'b0;
   logic          mem_rd, mem_wr, io_rd, io_wr;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BEATS(NB)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
      .req_burst(req_burst), .req_ack(req_ack), .rd_data(rd_data),
      .rd_valid(rd_valid), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_ready(bus_ready),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
   );

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_outs(string tg, logic [3:0] se, logic [AW-1:0] ae,
                             logic oe, logic [DW-1:0] de, logic rve,
                             logic [DW-1:0] rde, logic acke, string atag);
      chk(tg, "strobes", 64'({mem_rd, mem_wr, io_rd, io_wr}), 64'(se));
      chk(atag, "bus_addr", 64'(bus_addr), 64'(ae));
      chk(tg, "bus_dout_en", 64'(bus_dout_en), 64'(oe));
      chk(oe ? "R2" : "R10", "bus_dout", 64'(bus_dout), 64'(de));
      chk(tg, "rd_valid", 64'(rd_valid), 64'(rve));
      if (rve) chk(tg, "rd_data", 64'(rd_data), 64'(rde));
      chk("R9", "req_ack", 64'(req_ack), 64'(acke));
   endtask

   // Called at a falling edge with the controller idle; returns at a falling edge, idle.
   task automatic run_txn(logic [AW-1:0] a, logic [DW-1:0] wd, bit wr, bit io, bit bu, int wt);
      int nb;
      logic [3:0] se;
      string tg, atag;
      logic [DW-1:0] prev;
      logic pv;
      logic [AW-1:0] ak;
      nb   = (bu && !wr && !io) ? NB : 1;
      se   = 4'b1000 >> {io, wr};
      tg   = (bu && nb == 1) ? "R7" : (nb > 1) ? "R6" : io ? "R8" : wr ? "R4" : "R3";
      atag = (nb > 1) ? "R6" : "R2";
      prev = '0;
      pv   = 1'b0;
      check_outs("R10", 4'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, "R10");
      req_valid = 1'b1; req_addr = a; req_wdata = wd;
      req_write = wr; req_io = io; req_burst = bu;
      @(negedge clk);
      // R2: scramble the request after acceptance
      req_addr = ~a; req_wdata = ~wd; req_write = !wr; req_io = !io; req_burst = !bu;
      for (int k = 0; k < nb; k++) begin
         ak = a + AW'(k * BY);
         // address clock
         check_outs(tg, se, ak, 1'b0, '0, pv, prev, 1'b0, atag);
         bus_ready = 1'b1;   // R5: ready here must not be sampled
         bus_din = 16'hDEAD;
         pv = 1'b0;
         @(negedge clk);
         for (int j = 0; j <= wt; j++) begin
            check_outs(wt > 0 ? "R5" : tg, se, ak, wr, wr ? wd : '0, 1'b0, '0, 1'b0, atag);
            bus_ready = (j == wt);
            @(negedge clk);
         end
         // end clock
         check_outs(tg, se, ak, wr, wr ? wd : '0, 1'b0, '0, 1'b0, atag);
         prev = {8'hC3 ^ 8'(k), ak};
         bus_din = prev;
         pv = !wr;
         bus_ready = 1'b0;
         @(negedge clk);
      end
      // acknowledge clock
      check_outs("R9", 4'b0, '0, 1'b0, '0, pv, prev, 1'b1, "R10");
      req_valid = 1'b0;
      bus_din = 16'hBEEF;
      @(negedge clk);
      check_outs("R9", 4'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, "R10");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      check_outs("R1", 4'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      // R2: no request, no activity
      for (int i = 0; i < 3; i++) begin
         check_outs("R2", 4'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, "R2");
         @(negedge clk);
      end
      run_txn(8'h10, 16'h0000, 1'b0, 1'b0, 1'b0, 0);   // R3 memory read
      run_txn(8'h22, 16'hA5C3, 1'b1, 1'b0, 1'b0, 0);   // R4 memory write
      run_txn(8'h31, 16'h0000, 1'b0, 1'b1, 1'b0, 2);   // R8 / R5 I/O read
      run_txn(8'h40, 16'h1234, 1'b1, 1'b1, 1'b0, 3);   // R8 / R5 I/O write
      run_txn(8'h20, 16'h0000, 1'b0, 1'b0, 1'b1, 0);   // R6 burst
      run_txn(8'hFC, 16'h0000, 1'b0, 1'b0, 1'b1, 1);   // R6 burst wrap, R5
      run_txn(8'h50, 16'h7E81, 1'b1, 1'b0, 1'b1, 0);   // R7 burst on write
      run_txn(8'h60, 16'h0000, 1'b0, 1'b1, 1'b1, 1);   // R7 burst on I/O
      run_txn(8'h77, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1);   // R4 / R5
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule